// File: doc/BRIEF.md
# Pipelined Converter Sub-code Deskew and Redundancy Correction

This block sits behind a seven-stage pipelined analog-to-digital converter whose stages each resolve 2.5 bits. Every stage reports a 3-bit decision code, and all seven codes arrive together on one 21-bit bus. Because each stage works on the residue of the stage before it, the codes on the bus at any instant belong to seven different input samples. The block first delays each stage's code so that the seven codes of one sample line up. Only then does it remove the redundancy, by adding the signed stage digits with a two-bit shift between neighbours.

The corrected value is biased into offset binary and clipped to the converter's range. The block registers the result as a 21-bit output word together with an over-range flag, and raises a one-cycle data-ready strobe once the word can be used. A 3-bit mode input chooses what goes onto the output bus. In the correction mode the bus carries the clipped, corrected word. In every other mode it carries the aligned raw stage codes, which is useful when characterising the stages. All state advances on `smp_en`, the enable that marks the sampling phase edge of the system clock.

Top module: `adc_subcode_corrector`

## Requirements
- R1: Stage k (k = 1 for the first stage after the sample-and-hold, up to 7) uses bits [3(7-k)+2 : 3(7-k)] of `stage_codes`. Its code is delayed by 7-k sampling strobes, so stage 7 is not delayed at all and stage 1 is delayed by six strobes. The word registered at strobe t is built from stage k's code taken at strobe t-7+k.
- R2: Every stage code is an unsigned value from 0 to 6 and stands for the signed digit code-3.
- R3: In mode 3'b000 the aligned digits are summed as V = sum over k of (code_k-3)*4^(7-k). The biased result O = V+8192 appears in `out_word[13:0]` as offset binary, and `out_word[20:14]` is zero.
- R4: `out_range` is 1 exactly when O < 0 or O > 16383. When O < 0 the 14-bit word saturates to 0, and when O > 16383 it saturates to 16383.
- R5: In any mode other than 3'b000, `out_word` carries the seven aligned codes, packed with the same field positions as `stage_codes`. `out_range` still reports the over-range condition of R4 for that sample.
- R6: `out_word` and `out_range` change only at clock edges where `smp_en` is 1. Between such edges they hold their values, whatever is on `stage_codes` or `mode_sel`.
- R7: `data_rdy` is 1 for the single cycle that follows a strobe edge, provided at least six strobes have already occurred since reset. Otherwise it is 0.
- R8: While `rst_n` is low at a clock edge, `out_word`, `out_range` and `data_rdy` become 0, and the strobe count used by R7 restarts.
- R9: The value of `mode_sel` at a strobe edge selects the content of the word registered at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sampling strobe; one new set of stage codes per high cycle |
| mode_sel | input | 3 | Output content select: 000 corrected word, other values aligned raw codes |
| stage_codes | input | 21 | Skewed stage decision codes, 3 bits per stage, stage 1 in the top field |
| out_word | output | 21 | Registered output word |
| out_range | output | 1 | Registered over-range flag |
| data_rdy | output | 1 | One-cycle strobe marking a usable output word |

## Verification
The assertions assume that every code field on `stage_codes` lies between 0 and 6 whenever `smp_en` is high. They make no assumption about the bus during idle cycles. The stimulus draws each stage's code from a per-sample table that holds only legal values, and it builds the skewed bus from that table. On idle cycles the stimulus drives the illegal all-ones pattern, which shows that such values are ignored. Strobes are interleaved with regular idle gaps so that both the hold behaviour and the delay-by-strobe (not by-cycle) alignment are exercised. The mode input is switched between the correction mode and two raw-mode codes on alternate strobes.

// File: rtl/adc_corr_pkg.sv
// Package: shared constants and mode encoding for the sub-code corrector.
// Assumes 2.5-bit stages: 3-bit codes with seven legal values.
package adc_corr_pkg;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned MID_CODE = 3;
    localparam int unsigned TOP_CODE = 6;

    typedef enum logic [2:0] {
        MODE_CORR = 3'b000,
        MODE_RAW  = 3'b001
    } out_mode_e;
endpackage

// File: rtl/subcode_deskew.sv
// Module: subcode_deskew
// Delays each stage's code by (STAGES - k) sampling strobes so that the codes
// of one input sample line up. The last stage passes straight through.
// Assumes: codes are presented only on strobe cycles and lie in 0..TOP_CODE.
module subcode_deskew
    import adc_corr_pkg::*;
#(
    parameter int unsigned STAGES = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_en,
    input  logic [STAGES*CODE_W-1:0]   raw_i,
    output logic [STAGES*CODE_W-1:0]   algn_o
);
    localparam int unsigned BUS_W = STAGES * CODE_W;

    for (genvar k = 1; k <= STAGES; k++) begin : g_stg
        localparam int unsigned DLY = STAGES - k;
        localparam int unsigned LSB = CODE_W * (STAGES - k);

        // Input legality: a strobed code never exceeds the top code (R2).
        assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
            smp_en |-> (raw_i[LSB +: CODE_W] <= CODE_W'(TOP_CODE)));

        if (DLY == 0) begin : g_thru
            assign algn_o[LSB +: CODE_W] = raw_i[LSB +: CODE_W];
        end else begin : g_dly
            logic [CODE_W-1:0] tap [DLY];

            // Shift register advanced once per sampling strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < int'(DLY); i++) tap[i] <= '0;
                end else if (smp_en) begin
                    tap[0] <= raw_i[LSB +: CODE_W];
                    for (int i = 1; i < int'(DLY); i++) tap[i] <= tap[i-1];
                end
            end

            assign algn_o[LSB +: CODE_W] = tap[DLY-1];
        end
    end

    // The stage with a one-strobe delay presents last strobe's input code (R1).
    if (STAGES >= 2) begin : g_chk_align
        localparam int unsigned L1 = CODE_W;
        assert_one_strobe_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
            smp_en |=> (algn_o[L1 +: CODE_W] == $past(raw_i[L1 +: CODE_W])));
    end

    logic unused_bus;
    assign unused_bus = ^BUS_W;
endmodule

// File: rtl/redundancy_sum.sv
// Module: redundancy_sum
// Combinational overlapped addition: each aligned code becomes the signed
// digit (code - MID_CODE), weighted by 4^(STAGES-k), and all digits are summed.
// Assumes: SUM_W is wide enough for +/-(4^STAGES - 1) plus the output bias.
module redundancy_sum
    import adc_corr_pkg::*;
#(
    parameter int unsigned STAGES = 7,
    parameter int unsigned SUM_W  = 2 * STAGES + 2
) (
    input  logic [STAGES*CODE_W-1:0]  algn_i,
    output logic signed [SUM_W-1:0]   val_o
);
    logic signed [SUM_W-1:0] term [STAGES];

    for (genvar k = 1; k <= STAGES; k++) begin : g_term
        localparam int unsigned LSB = CODE_W * (STAGES - k);
        // Signed digit shifted into its two-bit-per-stage weight.
        assign term[k-1] = (SUM_W'(algn_i[LSB +: CODE_W]) - SUM_W'(MID_CODE))
                           << (2 * (STAGES - k));
    end

    // Accumulate every weighted digit into the corrected value.
    always_comb begin
        val_o = '0;
        for (int i = 0; i < int'(STAGES); i++) val_o = val_o + term[i];
    end
endmodule

// File: rtl/word_formatter.sv
// Module: word_formatter
// Biases the corrected value into offset binary, detects over-range,
// saturates, selects corrected or raw content, and registers the result on
// each sampling strobe.
// Assumes: BUS_W >= RES_W and SUM_W = RES_W + 2.
module word_formatter
    import adc_corr_pkg::*;
#(
    parameter int unsigned BUS_W = 21,
    parameter int unsigned RES_W = 14,
    parameter int unsigned SUM_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_en,
    input  logic [2:0]               mode_i,
    input  logic signed [SUM_W-1:0]  val_i,
    input  logic [BUS_W-1:0]         algn_i,
    output logic [BUS_W-1:0]         out_o,
    output logic                     ovr_o
);
    localparam logic [SUM_W-1:0] OFFS = SUM_W'(1) << (RES_W - 1);

    logic signed [SUM_W-1:0] biased;
    logic                    under, over;
    logic [RES_W-1:0]        sat_word;
    logic [BUS_W-1:0]        next_word;
    logic                    corr_q;

    // Bias into offset binary and classify against the code range.
    always_comb begin
        biased = val_i + $signed(OFFS);
        under  = biased[SUM_W-1];
        over   = !biased[SUM_W-1] && (|biased[SUM_W-2:RES_W]);
    end

    // Clip to the range and pick the bus content for the selected mode.
    always_comb begin
        if (under)     sat_word = '0;
        else if (over) sat_word = '1;
        else           sat_word = biased[RES_W-1:0];
        next_word = (mode_i == MODE_CORR) ? BUS_W'(sat_word) : algn_i;
    end

    // Output register, loaded only on a sampling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o  <= '0;
            ovr_o  <= 1'b0;
            corr_q <= 1'b1;
        end else if (smp_en) begin
            out_o  <= next_word;
            ovr_o  <= under || over;
            corr_q <= (mode_i == MODE_CORR);
        end
    end

    // Outputs hold between strobes (R6).
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> ($stable(out_o) && $stable(ovr_o)));

    // A flagged corrected word sits at one of the two rails (R4).
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && corr_q) |-> (out_o[RES_W-1:0] == '0 || out_o[RES_W-1:0] == '1));

    // A corrected word leaves the bits above the resolution clear (R3).
    assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        corr_q |-> (out_o[BUS_W-1:RES_W] == '0));
endmodule

// File: rtl/adc_subcode_corrector.sv
// Module: adc_subcode_corrector (top)
// Aligns the skewed stage codes, removes redundancy, formats the output word
// and produces the data-ready strobe once the delay lines hold real samples.
// Assumes: one strobe per sample; codes legal on strobe cycles.
module adc_subcode_corrector
    import adc_corr_pkg::*;
#(
    parameter int unsigned STAGES = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_en,
    input  logic [2:0]                  mode_sel,
    input  logic [STAGES*CODE_W-1:0]    stage_codes,
    output logic [STAGES*CODE_W-1:0]    out_word,
    output logic                        out_range,
    output logic                        data_rdy
);
    localparam int unsigned BUS_W = STAGES * CODE_W;
    localparam int unsigned RES_W = 2 * STAGES;
    localparam int unsigned SUM_W = RES_W + 2;
    localparam int unsigned CNT_W = $clog2(STAGES);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(STAGES - 1);

    logic [BUS_W-1:0]        algn;
    logic signed [SUM_W-1:0] val;
    logic [CNT_W-1:0]        fill_cnt;
    logic                    fill_full;

    subcode_deskew #(.STAGES(STAGES)) i_deskew (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .raw_i  (stage_codes),
        .algn_o (algn)
    );

    redundancy_sum #(.STAGES(STAGES), .SUM_W(SUM_W)) i_sum (
        .algn_i (algn),
        .val_o  (val)
    );

    word_formatter #(.BUS_W(BUS_W), .RES_W(RES_W), .SUM_W(SUM_W)) i_fmt (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .mode_i (mode_sel),
        .val_i  (val),
        .algn_i (algn),
        .out_o  (out_word),
        .ovr_o  (out_range)
    );

    assign fill_full = (fill_cnt == FILL_LAST);

    // Count strobes since reset until the longest delay line is full.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fill_cnt <= '0;
        else if (smp_en && !fill_full)  fill_cnt <= fill_cnt + 1'b1;
    end

    // Ready strobe for the cycle after a strobe that produced a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) data_rdy <= 1'b0;
        else        data_rdy <= smp_en && fill_full;
    end

    // Ready only follows a strobe edge (R7).
    assert_rdy_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> $past(smp_en));

    // Ready is never a two-cycle pulse unless strobes are back to back (R7).
    assert_rdy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && !smp_en) |=> !data_rdy);
endmodule

// File: tb/test_adc_subcode_corrector.sv
// Bench: skewed stage codes built from a per-sample table, strobes with idle
// gaps, modes switched, expected words computed arithmetically.
module test_adc_subcode_corrector;
    localparam int S     = 7;
    localparam int BW    = 21;
    localparam int NSAMP = 800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_en = 1'b0;
    logic [2:0]    mode_sel = 3'b000;
    logic [BW-1:0] stage_codes = '0;
    logic [BW-1:0] out_word;
    logic          out_range;
    logic          data_rdy;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  codes [NSAMP][S];

    adc_subcode_corrector i_adc_subcode_corrector (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .mode_sel(mode_sel),
        .stage_codes(stage_codes), .out_word(out_word),
        .out_range(out_range), .data_rdy(data_rdy)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Expected word and flag for sample s in mode m (R3, R4, R5).
    function automatic logic [BW-1:0] expect_word(input int s, input logic [2:0] m, output bit ov);
        int v = 0;
        int o;
        logic [BW-1:0] raw = '0;
        for (int k = 1; k <= S; k++) begin
            v += (codes[s][k-1] - 3) * (1 << (2 * (S - k)));
            raw[3*(S-k) +: 3] = 3'(codes[s][k-1]);
        end
        o  = v + 8192;
        ov = (o < 0) || (o > 16383);
        if (o < 0)     o = 0;
        if (o > 16383) o = 16383;
        return (m == 3'b000) ? BW'(o) : raw;
    endfunction

    // Skewed bus for strobe t: stage k shows sample t-k+1 (R1).
    function automatic logic [BW-1:0] bus_for(input int t);
        logic [BW-1:0] b = '0;
        for (int k = 1; k <= S; k++) begin
            int s = t - (k - 1);
            b[3*(S-k) +: 3] = (s >= 0 && s < NSAMP) ? 3'(codes[s][k-1]) : 3'd3;
        end
        return b;
    endfunction

    function automatic logic [2:0] mode_for(input int t);
        if (((t / 40) % 4) == 2) return (t % 2 != 0) ? 3'b001 : 3'b101;
        return 3'b000;
    endfunction

    task automatic set_sample(input int s, input int c1, input int c7);
        for (int k = 0; k < S; k++) codes[s][k] = 3;
        codes[s][0] = c1;
        codes[s][S-1] = c7;
    endtask

    // Run nstb strobes with idle gaps and check every edge's result.
    task automatic run_block(input int nstb);
        int t = 0, cyc = 0, pt = 0;
        bit pend = 0;
        logic [2:0] pm = 3'b000;
        logic [BW-1:0] last_out = '0;
        logic last_ovr = 1'b0;
        logic [BW-1:0] ew;
        bit eo;
        while (t < nstb || pend) begin
            @(negedge clk);
            if (pend) begin
                if (pt >= 6) begin
                    ew = expect_word(pt - 6, pm, eo);
                    chk("R7 ready after fill", BW'(data_rdy), BW'(1));
                    chk((pm == 3'b000) ? "R3/R1/R9 corrected word" : "R5/R1/R9 raw aligned word", out_word, ew);
                    chk("R4 over-range flag", BW'(out_range), BW'(eo));
                end else begin
                    chk("R7 no ready during fill", BW'(data_rdy), BW'(0));
                end
            end else if (cyc > 0) begin
                chk("R7 no ready after idle", BW'(data_rdy), BW'(0));
                chk("R6 word held", out_word, last_out);
                chk("R6 flag held", BW'(out_range), BW'(last_ovr));
            end
            last_out = out_word;
            last_ovr = out_range;
            if (t < nstb && (cyc % 5) != 4) begin
                smp_en = 1'b1;
                stage_codes = bus_for(t);
                mode_sel = mode_for(t);
                pend = 1; pt = t; pm = mode_sel; t++;
            end else begin
                smp_en = 1'b0;
                stage_codes = '1;
                mode_sel = 3'b111;
                pend = 0;
            end
            cyc++;
        end
        smp_en = 1'b0;
    endtask

    initial begin
        // Directed samples at the range corners (R2, R4).
        set_sample(0, 3, 3);   // V = 0
        for (int k = 0; k < S; k++) codes[1][k] = 6;   // far above range
        for (int k = 0; k < S; k++) codes[2][k] = 0;   // far below range
        set_sample(3, 5, 2);   // V = +8191, top code, no flag
        set_sample(4, 5, 3);   // V = +8192, just over
        set_sample(5, 1, 3);   // V = -8192, code 0, no flag
        set_sample(6, 1, 2);   // V = -8193, just under
        set_sample(7, 1, 4);   // V = -8191
        for (int i = 8; i < NSAMP; i++)
            for (int k = 1; k <= S; k++)
                codes[i][k-1] = (i + (i / 7) * k + k * k) % 7;

        repeat (3) @(negedge clk);
        chk("R8 reset word", out_word, '0);
        chk("R8 reset flag", BW'(out_range), BW'(0));
        chk("R8 reset ready", BW'(data_rdy), BW'(0));
        rst_n = 1'b1;
        run_block(NSAMP + 6);

        // Second reset mid-stream: outputs clear, fill count restarts (R8).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid-run reset word", out_word, '0);
        chk("R8 mid-run reset ready", BW'(data_rdy), BW'(0));
        rst_n = 1'b1;
        run_block(30);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule